// File: doc/BRIEF.md
# Shadowed Real-Time Clock Register Front End

This block sits between the byte-level engine of a serial real-time clock and the rest of the clock: the time and date counters, the alarm comparators and the oscillator monitor. The host sees a byte-addressed file of seventeen registers at addresses 00h to 10h. A single pointer walks through this file. It advances after every byte read or acknowledged write, and it wraps from the last address back to the first.

The seven time and date bytes (00h to 06h) are never read from the running counters. Instead, a shadow copy of all seven is taken together on a bus start, on a bus stop, and whenever the pointer rolls over to 00h. A burst read therefore returns one coherent instant while the counters keep running. Host writes to the time and date addresses go straight to the counters as single-cycle write strobes. A write to the seconds byte also restarts the sub-second prescaler. The alarm bytes (07h to 0Dh), control (0Eh), status (0Fh) and trickle-charge setup (10h) are held here and driven out to their users.

Top module: `rtc_regfront`

## Requirements
- R1: After each read strobe or write acknowledge (with no pointer load in the same cycle), the pointer moves to the next address; from 10h it moves to 00h.
- R2: A bus start copies all seven live time bytes into the shadow, and reads of 00h to 06h return the shadow.
- R3: A bus stop, and a pointer roll-over from 10h to 00h, also reload the shadow from the live time bytes.
- R4: A read of 00h to 06h is unaffected by changes of the live time bytes and by host writes to those addresses until the next reload. With no bus event in the previous cycle, the read data does not change.
- R5: A byte given with the write strobe is committed only on the following acknowledge. For 00h to 06h, one bit of the one-hot write enable (bit n for address n) is high for exactly the cycle after the acknowledge, with the masked byte on the write data. An acknowledge with no pending byte commits nothing.
- R6: Committing a write to 00h raises the prescaler clear for that same single cycle. Writes to other addresses leave it low.
- R7: Bits fixed at 0 always read and drive 0. The masks are: 00h 7Fh, 01h 7Fh, 02h 7Fh, 03h 07h, 04h 3Fh, 05h 9Fh, 0Eh BFh, 0Fh 83h; all other addresses use all eight bits.
- R8: The status byte holds the oscillator-fail flag in bit 7, the alarm 2 flag in bit 1 and the alarm 1 flag in bit 0. A set input raises its flag on the next edge. Writing 0 to a flag clears it, and writing 1 leaves it unchanged. A set input in the same cycle as a clearing write wins.
- R9: Writes to 07h to 0Dh, 0Eh and 10h are stored and appear on the alarm, control and trickle outputs on the next edge (alarm byte k at bits 8k+7 to 8k) and on read-back.
- R10: A reload captures the live value present in the cycle of the event, not the value that follows it.
- R11: After reset, the pointer is 00h, every stored byte and the shadow are 0, and no write strobe or prescaler clear is active.
- R12: A pointer load sets the pointer to the given value. A value above 10h sets it to 00h. A load takes precedence over advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStart | input | 1 | Bus start event pulse |
| busStop | input | 1 | Bus stop event pulse |
| ptrLoad | input | 1 | Load pointer from ptrValue |
| ptrValue | input | 5 | New pointer value |
| rdStrobe | input | 1 | Byte at pointer consumed by the host |
| wrStrobe | input | 1 | Host byte received on wrByte |
| wrByte | input | 8 | Received host byte |
| wrAck | input | 1 | Acknowledge of the received byte |
| liveTime | input | 56 | Live time bytes, byte n at bits 8n+7..8n |
| setOsf | input | 1 | Raise oscillator-fail flag |
| setA2 | input | 1 | Raise alarm 2 flag |
| setA1 | input | 1 | Raise alarm 1 flag |
| rdData | output | 8 | Byte at the current pointer |
| timeWrEn | output | 7 | One-hot write enable to time counters |
| timeWrData | output | 8 | Write data to time counters |
| prescalerClr | output | 1 | Sub-second prescaler clear pulse |
| alarmRegs | output | 56 | Alarm bytes 07h..0Dh |
| ctrlReg | output | 8 | Control byte |
| statusReg | output | 8 | Status flags |
| trickleReg | output | 8 | Trickle-charge setup byte |

## Verification
The hardest case to reach is a shadow reload caused by roll-over instead of by a start or a stop. The pointer has to sit on 10h, the live bytes must have moved since the last reload, and a single read or acknowledge must then carry the pointer to 00h with no other bus event. The stimulus loads the pointer to 10h, changes the live bytes, and reads one byte. It then also acknowledges a write at 10h, so that roll-over is checked from both kinds of advance. Capture at the event edge is tested by changing the live bytes in the cycle right after a start.

// File: rtl/rtc_regfront_pkg.sv
package rtc_regfront_pkg;
  localparam int DATA_W       = 8;
  localparam int ADDR_W       = 5;
  localparam int NUM_REGS     = 17;
  localparam int TIME_REGS    = 7;
  localparam int ALARM_BASE   = 7;
  localparam int ALARM_REGS   = 7;
  localparam int CTRL_ADDR    = 14;
  localparam int STATUS_ADDR  = 15;
  localparam int TRICKLE_ADDR = 16;
  localparam int SECONDS_ADDR = 0;
  localparam int LAST_ADDR    = NUM_REGS - 1;

  typedef struct packed {
    logic              shadowLoad;
    logic              commit;
    logic [ADDR_W-1:0] curAddr;
    logic [DATA_W-1:0] commitData;
  } regStrobes_t;

  // Bits that exist in each register; the rest are held at zero.
  function automatic logic [DATA_W-1:0] fieldMask(input logic [ADDR_W-1:0] addr);
    case (addr)
      5'd0, 5'd1, 5'd2: fieldMask = 8'h7F;
      5'd3:             fieldMask = 8'h07;
      5'd4:             fieldMask = 8'h3F;
      5'd5:             fieldMask = 8'h9F;
      5'd14:            fieldMask = 8'hBF;
      5'd15:            fieldMask = 8'h83;
      default:          fieldMask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_regfront_ctrl.sv
module rtc_regfront_ctrl
  import rtc_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrValue,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              wrAck,
  output regStrobes_t       strobes
);
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptrNext;
  logic [DATA_W-1:0] holdByte;
  logic              holdValid;
  logic              advance;
  logic              rollOver;

  assign advance  = (rdStrobe | wrAck) & ~ptrLoad;
  assign rollOver = advance & (ptr == ADDR_W'(LAST_ADDR));

  always_comb begin
    ptrNext = ptr;
    if (ptrLoad) begin
      ptrNext = (ptrValue > ADDR_W'(LAST_ADDR)) ? '0 : ptrValue;
    end else if (advance) begin
      ptrNext = rollOver ? '0 : ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      holdByte  <= '0;
      holdValid <= 1'b0;
    end else begin
      ptr <= ptrNext;
      if (busStart || busStop) begin
        holdValid <= 1'b0;
      end else if (wrStrobe) begin
        holdByte  <= wrByte;
        holdValid <= 1'b1;
      end else if (wrAck) begin
        holdValid <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.shadowLoad = busStart | busStop | rollOver;
    strobes.commit     = wrAck & holdValid;
    strobes.curAddr    = ptr;
    strobes.commitData = holdByte;
  end
endmodule

// File: rtl/rtc_regfront_dp.sv
module rtc_regfront_dp
  import rtc_regfront_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrobes_t                    strobes,
  input  logic [TIME_REGS*DATA_W-1:0]    liveTime,
  input  logic                           setOsf,
  input  logic                           setA2,
  input  logic                           setA1,
  output logic [DATA_W-1:0]              rdData,
  output logic [TIME_REGS-1:0]           timeWrEn,
  output logic [DATA_W-1:0]              timeWrData,
  output logic                           prescalerClr,
  output logic [ALARM_REGS*DATA_W-1:0]   alarmRegs,
  output logic [DATA_W-1:0]              ctrlReg,
  output logic [DATA_W-1:0]              statusReg,
  output logic [DATA_W-1:0]              trickleReg
);
  logic [DATA_W-1:0] shadow [TIME_REGS];
  logic [DATA_W-1:0] alarmByte [ALARM_REGS];
  logic [DATA_W-1:0] maskedData;
  logic [DATA_W-1:0] statusNext;
  logic              timeHit;

  assign maskedData = strobes.commitData & fieldMask(strobes.curAddr);
  assign timeHit    = strobes.commit && (strobes.curAddr < ADDR_W'(TIME_REGS));

  for (genvar i = 0; i < TIME_REGS; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadow[i] <= '0;
      end else if (strobes.shadowLoad) begin
        shadow[i] <= liveTime[i*DATA_W +: DATA_W] & fieldMask(ADDR_W'(i));
      end
    end
  end

  for (genvar j = 0; j < ALARM_REGS; j++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (!rstN) begin
        alarmByte[j] <= '0;
      end else if (strobes.commit && strobes.curAddr == ADDR_W'(ALARM_BASE + j)) begin
        alarmByte[j] <= maskedData;
      end
    end
    assign alarmRegs[j*DATA_W +: DATA_W] = alarmByte[j];
  end

  always_comb begin
    statusNext = statusReg;
    if (strobes.commit && strobes.curAddr == ADDR_W'(STATUS_ADDR)) begin
      statusNext = statusReg & strobes.commitData;
    end
    statusNext = (statusNext | {setOsf, 5'b0, setA2, setA1})
               & fieldMask(ADDR_W'(STATUS_ADDR));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg      <= '0;
      trickleReg   <= '0;
      statusReg    <= '0;
      timeWrEn     <= '0;
      timeWrData   <= '0;
      prescalerClr <= 1'b0;
    end else begin
      statusReg    <= statusNext;
      timeWrEn     <= '0;
      prescalerClr <= 1'b0;
      if (strobes.commit && strobes.curAddr == ADDR_W'(CTRL_ADDR)) begin
        ctrlReg <= maskedData;
      end
      if (strobes.commit && strobes.curAddr == ADDR_W'(TRICKLE_ADDR)) begin
        trickleReg <= maskedData;
      end
      if (timeHit) begin
        timeWrEn[strobes.curAddr[2:0]] <= 1'b1;
        timeWrData                     <= maskedData;
        prescalerClr <= (strobes.curAddr == ADDR_W'(SECONDS_ADDR));
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.curAddr < ADDR_W'(TIME_REGS)) begin
      rdData = shadow[strobes.curAddr[2:0]];
    end else if (strobes.curAddr < ADDR_W'(ALARM_BASE + ALARM_REGS)) begin
      rdData = alarmByte[3'(strobes.curAddr - ADDR_W'(ALARM_BASE))];
    end else if (strobes.curAddr == ADDR_W'(CTRL_ADDR)) begin
      rdData = ctrlReg;
    end else if (strobes.curAddr == ADDR_W'(STATUS_ADDR)) begin
      rdData = statusReg;
    end else if (strobes.curAddr == ADDR_W'(TRICKLE_ADDR)) begin
      rdData = trickleReg;
    end
  end
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
  import rtc_regfront_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busStart,
  input  logic                         busStop,
  input  logic                         ptrLoad,
  input  logic [ADDR_W-1:0]            ptrValue,
  input  logic                         rdStrobe,
  input  logic                         wrStrobe,
  input  logic [DATA_W-1:0]            wrByte,
  input  logic                         wrAck,
  input  logic [TIME_REGS*DATA_W-1:0]  liveTime,
  input  logic                         setOsf,
  input  logic                         setA2,
  input  logic                         setA1,
  output logic [DATA_W-1:0]            rdData,
  output logic [TIME_REGS-1:0]         timeWrEn,
  output logic [DATA_W-1:0]            timeWrData,
  output logic                         prescalerClr,
  output logic [ALARM_REGS*DATA_W-1:0] alarmRegs,
  output logic [DATA_W-1:0]            ctrlReg,
  output logic [DATA_W-1:0]            statusReg,
  output logic [DATA_W-1:0]            trickleReg
);
  regStrobes_t strobes;

  rtc_regfront_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busStart (busStart),
    .busStop  (busStop),
    .ptrLoad  (ptrLoad),
    .ptrValue (ptrValue),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .wrByte   (wrByte),
    .wrAck    (wrAck),
    .strobes  (strobes)
  );

  rtc_regfront_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .liveTime     (liveTime),
    .setOsf       (setOsf),
    .setA2        (setA2),
    .setA1        (setA1),
    .rdData       (rdData),
    .timeWrEn     (timeWrEn),
    .timeWrData   (timeWrData),
    .prescalerClr (prescalerClr),
    .alarmRegs    (alarmRegs),
    .ctrlReg      (ctrlReg),
    .statusReg    (statusReg),
    .trickleReg   (trickleReg)
  );
endmodule

// File: rtl/rtc_regfront_checker.sv
module rtc_regfront_checker
  import rtc_regfront_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busStart,
  input logic                 busStop,
  input logic                 ptrLoad,
  input logic                 rdStrobe,
  input logic                 wrAck,
  input logic                 setOsf,
  input logic                 setA2,
  input logic                 setA1,
  input logic [DATA_W-1:0]    rdData,
  input logic [TIME_REGS-1:0] timeWrEn,
  input logic                 prescalerClr,
  input logic [DATA_W-1:0]    ctrlReg,
  input logic [DATA_W-1:0]    statusReg
);
  logic quiet;
  assign quiet = !busStart && !busStop && !ptrLoad && !rdStrobe && !wrAck
              && !setOsf && !setA2 && !setA1;

  assert_wr_after_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timeWrEn != '0) |-> $past(wrAck));

  assert_wr_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(timeWrEn));

  assert_clr_with_seconds_R6: assert property (@(posedge clk) disable iff (!rstN)
    prescalerClr |-> timeWrEn[0]);

  assert_fixed_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[6:2] == 5'b0) && (ctrlReg[6] == 1'b0));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (setA1 || setA2) |=> (statusReg[0] || statusReg[1]));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> $stable(rdData));
endmodule

bind rtc_regfront rtc_regfront_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busStart     (busStart),
  .busStop      (busStop),
  .ptrLoad      (ptrLoad),
  .rdStrobe     (rdStrobe),
  .wrAck        (wrAck),
  .setOsf       (setOsf),
  .setA2        (setA2),
  .setA1        (setA1),
  .rdData       (rdData),
  .timeWrEn     (timeWrEn),
  .prescalerClr (prescalerClr),
  .ctrlReg      (ctrlReg),
  .statusReg    (statusReg)
);

// File: tb/rtc_regfront_bench.sv
`timescale 1ns/1ps
module rtc_regfront_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busStart = 0, busStop = 0, ptrLoad = 0, rdStrobe = 0, wrStrobe = 0, wrAck = 0;
  logic [4:0]  ptrValue = '0;
  logic [7:0]  wrByte = '0;
  logic [55:0] liveTime = '0;
  logic        setOsf = 0, setA2 = 0, setA1 = 0;
  logic [7:0]  rdData, timeWrData, ctrlReg, statusReg, trickleReg;
  logic [6:0]  timeWrEn;
  logic        prescalerClr;
  logic [55:0] alarmRegs;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit modelOn = 0;

  always #4 clk = ~clk;

  rtc_regfront u_rtc_regfront (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .ptrLoad(ptrLoad), .ptrValue(ptrValue), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .wrByte(wrByte), .wrAck(wrAck), .liveTime(liveTime),
    .setOsf(setOsf), .setA2(setA2), .setA1(setA1), .rdData(rdData),
    .timeWrEn(timeWrEn), .timeWrData(timeWrData), .prescalerClr(prescalerClr),
    .alarmRegs(alarmRegs), .ctrlReg(ctrlReg), .statusReg(statusReg),
    .trickleReg(trickleReg)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] mShadow [7];
  logic [7:0] mCfg [17];
  int         mPtr;
  logic [7:0] mHold;
  bit         mHoldV;
  logic [6:0] mWrEn;
  logic [7:0] mWrData;
  bit         mClr;

  function automatic logic [7:0] msk(int a);
    case (a)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h9F;
      14:      return 8'hBF;
      15:      return 8'h83;
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mShadow[i]) mShadow[i] = '0;
      foreach (mCfg[i]) mCfg[i] = '0;
      mPtr = 0; mHold = '0; mHoldV = 0; mWrEn = '0; mWrData = '0; mClr = 0;
    end else begin
      automatic bit reload = busStart || busStop;
      mWrEn = '0;
      mClr  = 0;
      if (wrAck && mHoldV) begin
        if (mPtr < 7) begin
          mWrEn[mPtr] = 1'b1;
          mWrData = mHold & msk(mPtr);
          mClr = (mPtr == 0);
        end else if (mPtr == 15) begin
          mCfg[15] = mCfg[15] & mHold;
        end else begin
          mCfg[mPtr] = mHold & msk(mPtr);
        end
      end
      mCfg[15] = (mCfg[15] | {setOsf, 5'b0, setA2, setA1}) & 8'h83;
      if (ptrLoad) begin
        mPtr = (ptrValue > 16) ? 0 : int'(ptrValue);
      end else if (rdStrobe || wrAck) begin
        if (mPtr == 16) begin
          mPtr = 0;
          reload = 1;
        end else begin
          mPtr++;
        end
      end
      if (reload) for (int i = 0; i < 7; i++) mShadow[i] = liveTime[i*8 +: 8] & msk(i);
      if (busStart || busStop) mHoldV = 0;
      else if (wrStrobe) begin mHold = wrByte; mHoldV = 1; end
      else if (wrAck) mHoldV = 0;
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && modelOn && !finished) begin
      automatic logic [7:0] expRd;
      automatic logic [55:0] expAl;
      expRd = (mPtr < 7) ? mShadow[mPtr] : mCfg[mPtr];
      for (int k = 0; k < 7; k++) expAl[k*8 +: 8] = mCfg[7+k];
      chk("R4 model rdData", rdData, expRd);
      chk("R5 model timeWrEn", timeWrEn, mWrEn);
      chk("R5 model timeWrData", timeWrData, mWrData);
      chk("R6 model prescalerClr", prescalerClr, mClr);
      chk("R8 model statusReg", statusReg, mCfg[15]);
      chk("R9 model ctrlReg", ctrlReg, mCfg[14]);
      chk("R9 model trickleReg", trickleReg, mCfg[16]);
      chk("R9 model alarmRegs", alarmRegs, expAl);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic loadPtr(logic [4:0] v);
    ptrLoad = 1; ptrValue = v; tick(); ptrLoad = 0;
  endtask

  task automatic readByte(output logic [7:0] b);
    b = rdData; rdStrobe = 1; tick(); rdStrobe = 0;
  endtask

  task automatic writeByte(logic [7:0] d);
    wrStrobe = 1; wrByte = d; tick(); wrStrobe = 0;
    wrAck = 1; tick(); wrAck = 0;
  endtask

  function automatic logic [55:0] pack(logic [7:0] b0, b1, b2, b3, b4, b5, b6);
    return {b6, b5, b4, b3, b2, b1, b0};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] exp1 [7];
    exp1 = '{8'h58, 8'h59, 8'h23, 8'h05, 8'h31, 8'h89, 8'h24};
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    modelOn = 1;
    // R11 reset state
    chk("R11 rdData", rdData, 8'h00);
    chk("R11 timeWrEn", timeWrEn, 7'h0);
    chk("R11 prescalerClr", prescalerClr, 1'b0);
    chk("R11 statusReg", statusReg, 8'h00);

    // R2 / R10 / R7: start captures value of the event cycle
    liveTime = pack(8'h58, 8'h59, 8'h23, 8'hFD, 8'h31, 8'h89, 8'h24);
    busStart = 1; tick(); busStart = 0;
    liveTime = pack(8'h10, 8'h11, 8'h12, 8'h02, 8'h13, 8'h01, 8'h25);
    for (int i = 0; i < 7; i++) begin
      readByte(b);
      chk($sformatf("R2 R10 R7 burst byte %0d", i), b, exp1[i]);
    end

    // R3 stop reload
    busStop = 1; tick(); busStop = 0;
    loadPtr(0);
    chk("R3 stop reload seconds", rdData, 8'h10);

    // R1 / R3 wrap reload on read
    loadPtr(16);
    liveTime = pack(8'h42, 8'h07, 8'h08, 8'h03, 8'h09, 8'h12, 8'h30);
    readByte(b);
    chk("R1 R3 wrap reload", rdData, 8'h42);

    // R12 pointer load and out-of-range load
    loadPtr(5);
    chk("R12 load 5", rdData, 8'h12);
    loadPtr(20);
    chk("R12 load above range", rdData, 8'h42);

    // R5 / R6 / R7 seconds write
    loadPtr(0);
    writeByte(8'hB0);
    chk("R5 seconds enable", timeWrEn, 7'h01);
    chk("R7 seconds masked data", timeWrData, 8'h30);
    chk("R6 prescaler clear", prescalerClr, 1'b1);
    tick();
    chk("R5 single pulse", timeWrEn, 7'h00);
    loadPtr(0);
    chk("R4 write leaves shadow", rdData, 8'h42);
    loadPtr(1);
    writeByte(8'h45);
    chk("R5 minutes enable", timeWrEn, 7'h02);
    chk("R6 no clear on minutes", prescalerClr, 1'b0);

    // R5 ack without pending byte
    wrAck = 1; tick(); wrAck = 0;
    chk("R5 bare ack no write", timeWrEn, 7'h00);

    // R9 / R7 config registers
    loadPtr(14);
    writeByte(8'hFF);
    chk("R7 R9 control masked", ctrlReg, 8'hBF);
    loadPtr(14);
    chk("R9 control readback", rdData, 8'hBF);
    loadPtr(7);
    writeByte(8'h81);
    writeByte(8'h12);
    chk("R9 alarm byte 0", alarmRegs[7:0], 8'h81);
    chk("R9 alarm byte 1", alarmRegs[15:8], 8'h12);
    liveTime = pack(8'h33, 8'h07, 8'h08, 8'h03, 8'h09, 8'h12, 8'h30);
    loadPtr(16);
    writeByte(8'hA5);
    chk("R9 trickle", trickleReg, 8'hA5);
    chk("R1 R3 wrap on ack", rdData, 8'h33);

    // R8 status flags
    setA1 = 1; setA2 = 1; setOsf = 1; tick(); setA1 = 0; setA2 = 0; setOsf = 0;
    chk("R8 flags set", statusReg, 8'h83);
    loadPtr(15);
    writeByte(8'hFE);
    chk("R8 clear A1 only", statusReg, 8'h82);
    loadPtr(15);
    writeByte(8'h7F);
    chk("R8 clear OSF keep A2", statusReg, 8'h02);
    loadPtr(15);
    wrStrobe = 1; wrByte = 8'h00; tick(); wrStrobe = 0;
    wrAck = 1; setA2 = 1; tick(); wrAck = 0; setA2 = 0;
    chk("R8 set beats clear", statusReg, 8'h02);
    loadPtr(15);
    chk("R8 status readback", rdData, 8'h02);

    // R4 live change with no event leaves read data
    loadPtr(2);
    liveTime = '1;
    tick();
    chk("R4 live change ignored", rdData, 8'h08);

    tick();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule